// File: doc/BRIEF.md
# Asynchronous Serial Receive Framer

This block turns an asynchronous serial line into characters. A baud generator supplies a single-cycle oversampling tick, `OVERSAMPLE` ticks per bit. A low level on the line that follows a high level starts a candidate character. The candidate is only accepted if the line is still low at the middle of the start bit. The block then samples each data bit, the optional parity bit and one or two stop bits at the middle of its bit period.

Four static inputs set the frame shape: the character length, parity enable, parity sense and stop-bit count. The block captures them when a start bit is accepted, so they apply to that whole character. Each finished character leaves on a valid/ready stream, together with three flags: parity error, framing error and break. The stream feeds a receive FIFO. The character is delivered even when it carries errors.

The output stage holds one character. While `rxo_valid` is high and `rxo_ready` is low, the data and flags stay stable. A character that completes in that state is discarded. Two sticky error outputs gather parity and framing errors until a clear pulse arrives.

Top module: `uart_rx_framer`

## Requirements
- R1: `cfg_len` selects the data length: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Bits arrive least significant first, and unused upper bits of `rxo_data` read as zero.
- R2: A start is taken only on a high-to-low change seen between two consecutive ticks, with the line still low `OVERSAMPLE/2` ticks later. A shorter low pulse produces no character.
- R3: After an accepted start, each further bit is sampled exactly `OVERSAMPLE` ticks after the previous one, which puts every sample near the middle of its bit.
- R4: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 1 demands an odd count of ones over data plus parity, and 0 demands an even count. A mismatch sets `rxo_perr` for that character. With parity off, `rxo_perr` is 0.
- R5: `cfg_two_stop` = 0 expects one stop bit and 1 expects two. `rxo_ferr` is set when any expected stop bit is sampled low, and both are checked in two-stop mode.
- R6: `rxo_brk` is 1 exactly when `rxo_ferr` is 1 and all delivered data bits are zero.
- R7: A character with parity or framing errors is still delivered, with its error flags beside its data.
- R8: `sticky_perr` and `sticky_ferr` go high one cycle after a character with the matching error completes. They stay high until `err_clear` is sampled high. If an error completes in the same cycle as a clear, the flag is set.
- R9: While `rxo_valid` = 1 and `rxo_ready` = 0, `rxo_valid` and the output character stay unchanged, and a character that completes meanwhile is discarded.
- R10: The configuration inputs are captured when a start bit is accepted. Changing them during a character does not alter that character.
- R11: After a character whose last stop bit was low, no new character starts until the line has been seen high and then low again, so a long break yields a single character.
- R12: After reset, `rxo_valid`, `sticky_perr` and `sticky_ferr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, OVERSAMPLE per bit |
| rx_line | input | 1 | Serial line, idles high |
| cfg_len | input | 2 | Character length code (R1) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 two stop bits, 0 one |
| err_clear | input | 1 | Clears the sticky error outputs |
| rxo_valid | output | 1 | Character available |
| rxo_ready | input | 1 | Consumer accepts the character |
| rxo_data | output | 8 | Received character |
| rxo_perr | output | 1 | Parity error for this character |
| rxo_ferr | output | 1 | Framing error for this character |
| rxo_brk | output | 1 | Break detected for this character |
| sticky_perr | output | 1 | Accumulated parity error |
| sticky_ferr | output | 1 | Accumulated framing error |

## Verification
The line passes through `SYNC_STAGES` flops and is then sampled on ticks. The final stop bit is sampled at mid-bit, and the internal completion pulse follows one clock later. `rxo_valid` and the sticky flags rise one further clock after that. The bench therefore does not count to a fixed cycle. Its driver queues the expected character when it builds a frame, and a monitor compares each item when it sees `valid && ready` at a falling clock edge. Absence checks (a glitch, a break, a discarded character) and sticky-flag checks are made only after an idle gap of two bit times, well past the latest cycle at which a result could appear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 2;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             two_stop;
  } rx_cfg_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;

  // Index of the last data bit: code 0 -> bit 7, code 3 -> bit 4.
  function automatic logic [IDX_W-1:0] last_bit_idx(input logic [LEN_W-1:0] code);
    return IDX_W'(DATA_W - 1) - IDX_W'(code);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  rx_cfg_t  cfg_in,
  output logic     done,
  output rx_char_t done_char
);
  localparam int TW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int HALF = OVERSAMPLE / 2;
  localparam logic [TW-1:0] T_MID  = TW'(HALF - 1);
  localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);

  rx_state_e         state;
  rx_cfg_t           cfg_q;
  logic [TW-1:0]     tcnt;
  logic [IDX_W-1:0]  bcnt;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              stop_bad;
  logic              prev_line;

  logic bit_due;
  logic mid_due;
  assign bit_due = tick && (tcnt == T_LAST);
  assign mid_due = tick && (tcnt == T_MID);

  // Result of the final stop sample, formed from the current line level.
  logic     fin_ferr;
  logic     fin_perr;
  rx_char_t fin_char;
  always_comb begin
    fin_ferr = stop_bad | ~line;
    fin_perr = cfg_q.par_en & ((^shreg) ^ par_bit ^ cfg_q.par_odd);
    fin_char.data = shreg;
    fin_char.perr = fin_perr;
    fin_char.ferr = fin_ferr;
    fin_char.brk  = fin_ferr & (shreg == '0);
  end

  logic finish;
  assign finish = bit_due &&
                  (((state == ST_STOP1) && !cfg_q.two_stop) || (state == ST_STOP2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      tcnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      stop_bad  <= 1'b0;
      prev_line <= 1'b1;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          prev_line <= line;
          if (prev_line && !line) begin
            state <= ST_START;
            tcnt  <= '0;
            cfg_q <= cfg_in;
          end
        end
        ST_START: begin
          if (mid_due) begin
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
            stop_bad <= 1'b0;
            if (!line) begin
              state <= ST_DATA;
            end else begin
              state     <= ST_IDLE;
              prev_line <= line;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_due) begin
            tcnt <= '0;
            shreg[bcnt] <= line;
            if (bcnt == last_bit_idx(cfg_q.len)) begin
              state <= cfg_q.par_en ? ST_PAR : ST_STOP1;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_due) begin
            tcnt    <= '0;
            par_bit <= line;
            state   <= ST_STOP1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP1: begin
          if (bit_due) begin
            tcnt     <= '0;
            stop_bad <= ~line;
            if (cfg_q.two_stop) begin
              state <= ST_STOP2;
            end else begin
              state     <= ST_IDLE;
              prev_line <= line;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP2: begin
          if (bit_due) begin
            tcnt      <= '0;
            state     <= ST_IDLE;
            prev_line <= line;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_char <= '0;
    end else begin
      done <= finish;
      if (finish) done_char <= fin_char;
    end
  end
endmodule

// File: rtl/uart_rx_outbuf.sv
module uart_rx_outbuf
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_char_t done_char,
  input  logic     err_clear,
  output logic     out_valid,
  input  logic     out_ready,
  output rx_char_t out_char,
  output logic     sticky_perr,
  output logic     sticky_ferr
);
  logic can_load;
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_char  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (done && can_load) begin
        out_valid <= 1'b1;
        out_char  <= done_char;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_perr <= 1'b0;
      sticky_ferr <= 1'b0;
    end else begin
      if (done && done_char.perr) sticky_perr <= 1'b1;
      else if (err_clear)         sticky_perr <= 1'b0;
      if (done && done_char.ferr) sticky_ferr <= 1'b1;
      else if (err_clear)         sticky_ferr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              err_clear,
  output logic              rxo_valid,
  input  logic              rxo_ready,
  output logic [DATA_W-1:0] rxo_data,
  output logic              rxo_perr,
  output logic              rxo_ferr,
  output logic              rxo_brk,
  output logic              sticky_perr,
  output logic              sticky_ferr
);
  logic     line_s;
  rx_cfg_t  cfg_in;
  logic     done;
  rx_char_t done_char;
  rx_char_t out_char;

  assign cfg_in.len      = cfg_len;
  assign cfg_in.par_en   = cfg_par_en;
  assign cfg_in.par_odd  = cfg_par_odd;
  assign cfg_in.two_stop = cfg_two_stop;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) i_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .line     (line_s),
    .cfg_in   (cfg_in),
    .done     (done),
    .done_char(done_char)
  );

  uart_rx_outbuf i_outbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .done_char  (done_char),
    .err_clear  (err_clear),
    .out_valid  (rxo_valid),
    .out_ready  (rxo_ready),
    .out_char   (out_char),
    .sticky_perr(sticky_perr),
    .sticky_ferr(sticky_ferr)
  );

  assign rxo_data = out_char.data;
  assign rxo_perr = out_char.perr;
  assign rxo_ferr = out_char.ferr;
  assign rxo_brk  = out_char.brk;
endmodule

// File: rtl/uart_rx_framer_chk.sv
module uart_rx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxo_valid,
  input logic       rxo_ready,
  input logic [7:0] rxo_data,
  input logic       rxo_perr,
  input logic       rxo_ferr,
  input logic       rxo_brk,
  input logic       sticky_perr,
  input logic       sticky_ferr,
  input logic       err_clear,
  input logic       done,
  input logic       done_perr,
  input logic       done_ferr
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rxo_valid && !rxo_ready |=> rxo_valid); // R9
  AST_HOLD_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    rxo_valid && !rxo_ready |=> $stable(rxo_data) && $stable(rxo_perr) && $stable(rxo_ferr) && $stable(rxo_brk)); // R9
  AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rxo_valid && rxo_brk |-> rxo_ferr && (rxo_data == 8'h00)); // R6
  AST_FERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_ferr |=> sticky_ferr); // R8
  AST_PERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_perr |=> sticky_perr); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear && !done |=> !sticky_perr && !sticky_ferr); // R8
  AST_FERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_ferr && !err_clear |=> sticky_ferr); // R8
endmodule

bind uart_rx_framer uart_rx_framer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxo_valid  (rxo_valid),
  .rxo_ready  (rxo_ready),
  .rxo_data   (rxo_data),
  .rxo_perr   (rxo_perr),
  .rxo_ferr   (rxo_ferr),
  .rxo_brk    (rxo_brk),
  .sticky_perr(sticky_perr),
  .sticky_ferr(sticky_ferr),
  .err_clear  (err_clear),
  .done       (done),
  .done_perr  (done_char.perr),
  .done_ferr  (done_char.ferr)
);

// File: tb/test_uart_rx_framer.sv
module test_uart_rx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int OS         = 4;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = OS * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       err_clear = 1'b0;
  logic       rxo_valid;
  logic       rxo_ready = 1'b1;
  logic [7:0] rxo_data;
  logic       rxo_perr, rxo_ferr, rxo_brk;
  logic       sticky_perr, sticky_ferr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always_ff @(posedge clk) tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
  assign os_tick = (tdiv == 0);

  uart_rx_framer #(.OVERSAMPLE(OS), .SYNC_STAGES(2)) i_uart_rx_framer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .err_clear(err_clear),
    .rxo_valid(rxo_valid), .rxo_ready(rxo_ready), .rxo_data(rxo_data),
    .rxo_perr(rxo_perr), .rxo_ferr(rxo_ferr), .rxo_brk(rxo_brk),
    .sticky_perr(sticky_perr), .sticky_ferr(sticky_ferr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compares every accepted character against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rxo_valid && rxo_ready) begin
      logic [10:0] got;
      got = {rxo_data, rxo_perr, rxo_ferr, rxo_brk};
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R11 unexpected character", int'(got), 0);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, int'(got), int'(e));
      end
    end
  end

  task automatic put_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] len, input bit pe,
                      input bit odd, input bit two, input bit bad_par,
                      input logic [1:0] stop_lo, input int hold_low,
                      input bit expect_out, input bit swap, input string tag);
    int n;
    logic [7:0] dm;
    logic par, ferr, perr, brk;
    n = 8 - int'(len);
    dm = d & 8'((1 << n) - 1);
    par = (^dm) ^ odd ^ bad_par;
    ferr = stop_lo[0] | (two & stop_lo[1]);
    perr = pe & bad_par;
    brk = ferr && (dm == 8'h00);
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = odd; cfg_two_stop = two;
    if (expect_out) begin
      exp_q.push_back({dm, perr, ferr, brk});
      tag_q.push_back(tag);
    end
    put_bit(1'b0);
    if (swap) begin
      cfg_len = len + 2'd1; cfg_par_en = ~pe; cfg_two_stop = ~two; cfg_par_odd = ~odd;
    end
    for (int i = 0; i < n; i++) put_bit(dm[i]);
    if (pe) put_bit(par);
    put_bit(~stop_lo[0]);
    if (two) put_bit(~stop_lo[1]);
    for (int i = 0; i < hold_low; i++) put_bit(1'b0);
    put_bit(1'b1);
    put_bit(1'b1);
    cfg_len = len; cfg_par_en = pe; cfg_par_odd = odd; cfg_two_stop = two;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rxo_valid == 1'b0, "R12 valid after reset", rxo_valid, 0);
    check(sticky_perr == 1'b0, "R12 sticky_perr after reset", sticky_perr, 0);
    check(sticky_ferr == 1'b0, "R12 sticky_ferr after reset", sticky_ferr, 0);
    repeat (BIT_CLK) @(negedge clk);

    // R1 R3: all four lengths, clean frames
    send(8'hA5, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R1 8-bit char");
    send(8'hFF, 2'd1, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R1 7-bit char upper zero");
    send(8'h2B, 2'd2, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R1 6-bit char");
    send(8'h1E, 2'd3, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R1 5-bit char");
    send(8'h5A, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R3 alternating bits");
    // R4 parity
    send(8'h37, 2'd0, 1, 0, 0, 0, 2'b00, 0, 1, 0, "R4 even parity good");
    send(8'h37, 2'd0, 1, 1, 0, 0, 2'b00, 0, 1, 0, "R4 odd parity good");
    send(8'h12, 2'd1, 1, 1, 1, 1, 2'b00, 0, 1, 0, "R4 R7 odd parity bad delivered");
    check(sticky_perr == 1'b1, "R8 sticky_perr set", sticky_perr, 1);
    send(8'h40, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R8 good char after perr");
    check(sticky_perr == 1'b1, "R8 sticky_perr held", sticky_perr, 1);
    check(sticky_ferr == 1'b0, "R8 sticky_ferr still clear", sticky_ferr, 0);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
    check(sticky_perr == 1'b0, "R8 sticky_perr cleared", sticky_perr, 0);
    // R5 stop checks
    send(8'hC3, 2'd0, 0, 0, 1, 0, 2'b00, 0, 1, 0, "R5 two stop good");
    send(8'hC3, 2'd0, 0, 0, 1, 0, 2'b10, 0, 1, 0, "R5 R7 second stop low");
    check(sticky_ferr == 1'b1, "R8 sticky_ferr set", sticky_ferr, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
    check(sticky_ferr == 1'b0, "R8 sticky_ferr cleared", sticky_ferr, 0);
    send(8'h81, 2'd0, 1, 0, 0, 0, 2'b01, 0, 1, 0, "R5 single stop low");
    // R6 R11 break: long low, a single char
    send(8'h00, 2'd0, 0, 0, 0, 0, 2'b01, 4, 1, 0, "R6 R11 break char");
    send(8'h00, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R6 zero without ferr no brk");
    // R10 configuration change mid-character
    send(8'h9C, 2'd1, 1, 0, 0, 0, 2'b00, 0, 1, 1, "R10 cfg latched at start");
    // R2 glitch rejection
    rx_line = 1'b0; repeat (6) @(negedge clk); rx_line = 1'b1;
    repeat (3*BIT_CLK) @(negedge clk);
    check(rxo_valid == 1'b0, "R2 glitch gives no char", rxo_valid, 0);
    send(8'h66, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R2 char after glitch");
    // R9 back-pressure: second char dropped
    rxo_ready = 1'b0;
    send(8'h3C, 2'd0, 0, 0, 0, 0, 2'b00, 0, 1, 0, "R9 held char");
    send(8'hE7, 2'd0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R9 dropped char");
    check(rxo_valid == 1'b1, "R9 valid held", rxo_valid, 1);
    check(rxo_data == 8'h3C, "R9 data held", rxo_data, 8'h3C);
    rxo_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(rxo_valid == 1'b0, "R9 valid drops after accept", rxo_valid, 0);
    repeat (BIT_CLK) @(negedge clk);
    check(exp_q.size() == 0, "R7 all expected chars delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule